// File: doc/BRIEF.md
# NAND Page Read Sequencer with On-Die Correction Status

This block reads part or all of one page from a large-page NAND flash device whose own correction engine repairs the data while it moves the page from the array into the device's page buffer. A page is 2048 data bytes plus a 64-byte spare area. The device keeps its check bytes in 48 of the spare bytes, so 16 remain free for user metadata. The host supplies a column, a row and a byte count. The sequencer drives the 8-bit flash bus and returns the bytes on a valid/ready stream. The bytes come out already corrected by the device, and no correction is applied on the host side.

The read differs from a plain page read in one place. After the array load completes, the sequencer reads the device status byte to learn whether the load found a correctable or an uncorrectable error. Reading status leaves the device in status-output mode. The sequencer therefore sends the read command byte again, this time with no address, to put the device back into data-output mode before it strobes out any data. The correction outcome is latched on result outputs together with a one-cycle done pulse. A ready/busy timeout ends the operation early if the device never reports ready.

The IO pad is split into an output byte, an output enable and an input byte. The tri-state buffer sits outside this block.

Top module: `nandPageReader`

## Requirements
- R1: An accepted request produces these write cycles in order: a CLE cycle with byte 0x00, then five ALE cycles, then a CLE cycle with byte 0x30. The five ALE bytes are column[7:0], then {4'b0, column[11:8]}, then row[7:0], row[15:8] and row[23:16].
- R2: After the 0x30 cycle, no further command is issued until T_WB cycles have elapsed and R/B# has returned high. WE# and RE# stay high while R/B# is low.
- R3: Once the device is ready, the block issues a CLE cycle with 0x70 and one RE# read of the status byte. It then issues a CLE cycle with 0x00 and no address cycles, followed by exactly one RE# pulse per requested byte.
- R4: On the done pulse, resUncorr equals status bit 0 (uncorrectable error) and resCorr equals status bit 3 (corrected error). The results hold until the next request is accepted, and doneStb is high for exactly one cycle.
- R5: The stream carries exactly reqLen bytes (1 to 2112). These are the buffer bytes starting at reqCol, in order, and dataLast is set only on the final byte.
- R6: While dataValid is high and dataReady is low, dataByte and dataLast hold steady. No RE# pulse begins while a byte is waiting.
- R7: nandIoOe is high only during CLE or ALE write cycles, and never while RE# is low.
- R8: Every WE# low pulse lasts T_WE cycles and every RE# low pulse lasts T_RE cycles. CLE, ALE and the IO byte are already stable when WE# falls and are still driven when WE# rises.
- R9: If R/B# stays low for TIMEOUT_CYC cycles after the confirm, the block pulses done with resTimeout=1 and both correction flags at 0. It issues no status command and streams no data.
- R10: During and straight after reset, the block is idle: reqReady=1, WE#=RE#=1, CLE=ALE=0, IO not driven, no valid data, no done pulse, and all result flags at 0.
- R11: reqReady is high only when the block is idle. It drops in the cycle after a request is accepted and stays low until the operation has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Sequencer idle, request taken when valid |
| reqCol | input | 12 | Starting column within the page |
| reqRow | input | 24 | Row (page) address |
| reqLen | input | 12 | Bytes to read, 1 to 2112 |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandRbN | input | 1 | Ready/busy from the device, low while busy |
| nandIoOut | output | 8 | Byte driven onto the IO bus |
| nandIoOe | output | 1 | IO output enable |
| nandIoIn | input | 8 | Byte sampled from the IO bus |
| dataValid | output | 1 | Stream byte available |
| dataReady | input | 1 | Stream consumer accepts byte |
| dataByte | output | 8 | Stream byte |
| dataLast | output | 1 | Final byte of the transfer |
| doneStb | output | 1 | One-cycle end-of-operation pulse |
| resUncorr | output | 1 | Device reported an uncorrectable error |
| resCorr | output | 1 | Device reported a corrected error |
| resTimeout | output | 1 | Ready/busy timeout occurred |

## Verification
The checks on the bus rely on the device keeping R/B# high during every command and address cycle and pulling it low only after the 0x30 confirm. The bench's device model follows that rule: it drops R/B# on the confirm strobe and holds it low for a set number of cycles, or indefinitely in the timeout case. The stream checks assume that dataReady is a free-running input and that reqLen stays within 1 to 2112 with the range ending inside the 2112-byte page. Every vector keeps the column plus the length inside that bound. The stall masks never hold dataReady low for good, so every transfer completes.

// File: rtl/nandRdPkg.sv
package nandRdPkg;

  localparam logic [7:0] CMD_READ    = 8'h00;
  localparam logic [7:0] CMD_CONFIRM = 8'h30;
  localparam logic [7:0] CMD_STATUS  = 8'h70;

  typedef enum logic [2:0] {
    TMR_SETUP,
    TMR_WE,
    TMR_HOLD,
    TMR_RE,
    TMR_REH,
    TMR_WB
  } tmrSel_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic       reqAccept;
    logic       tmrStart;
    tmrSel_e    tmrSel;
    logic       shiftAddr;
    logic       ioUseAddr;
    logic [7:0] cmdByte;
    logic       capStatus;
    logic       capData;
    logic       busyClr;
    logic       busyEn;
    logic       setTimeout;
  } dpStrobe_t;

endpackage

// File: rtl/nandRdDatapath.sv
module nandRdDatapath
  import nandRdPkg::*;
#(
  parameter int COL_W       = 12,
  parameter int ROW_W       = 24,
  parameter int LEN_W       = 12,
  parameter int TMR_W       = 8,
  parameter int T_SETUP     = 2,
  parameter int T_WE        = 2,
  parameter int T_HOLD      = 1,
  parameter int T_RE        = 2,
  parameter int T_REH       = 1,
  parameter int T_WB        = 4,
  parameter int TIMEOUT_CYC = 2000,
  parameter int BIT_UNCORR  = 0,
  parameter int BIT_CORR    = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [COL_W-1:0] reqCol,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [7:0]       nandIoIn,
  input  logic             dataReady,
  output logic             tmrDone,
  output logic             addrLast,
  output logic             bytesDone,
  output logic             busyTimeout,
  output logic [7:0]       nandIoOut,
  output logic             dataValid,
  output logic [7:0]       dataByte,
  output logic             dataLast,
  output logic             resUncorr,
  output logic             resCorr,
  output logic             resTimeout
);

  localparam int COL_CYC  = (COL_W + 7) / 8;
  localparam int ROW_CYC  = (ROW_W + 7) / 8;
  localparam int ADDR_CYC = COL_CYC + ROW_CYC;
  localparam int ADDR_W   = ADDR_CYC * 8;
  localparam int ACNT_W   = $clog2(ADDR_CYC + 1);
  localparam int BUSY_W   = $clog2(TIMEOUT_CYC + 1);

  localparam logic [TMR_W-1:0] DUR_SETUP = TMR_W'(T_SETUP - 1);
  localparam logic [TMR_W-1:0] DUR_WE    = TMR_W'(T_WE - 1);
  localparam logic [TMR_W-1:0] DUR_HOLD  = TMR_W'(T_HOLD - 1);
  localparam logic [TMR_W-1:0] DUR_RE    = TMR_W'(T_RE - 1);
  localparam logic [TMR_W-1:0] DUR_REH   = TMR_W'(T_REH - 1);
  localparam logic [TMR_W-1:0] DUR_WB    = TMR_W'(T_WB - 1);

  logic [TMR_W-1:0]  tmr;
  logic [ADDR_W-1:0] addrSr;
  logic [ACNT_W-1:0] addrLeft;
  logic [LEN_W-1:0]  byteLeft;
  logic [BUSY_W-1:0] busyCnt;
  logic [ADDR_W-1:0] addrInit;

  // column bytes sit in the low cycles, row bytes above them
  assign addrInit = {(ROW_CYC*8)'(reqRow), (COL_CYC*8)'(reqCol)};

  // phase timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (stb.tmrStart) begin
      case (stb.tmrSel)
        TMR_SETUP: tmr <= DUR_SETUP;
        TMR_WE:    tmr <= DUR_WE;
        TMR_HOLD:  tmr <= DUR_HOLD;
        TMR_RE:    tmr <= DUR_RE;
        TMR_REH:   tmr <= DUR_REH;
        TMR_WB:    tmr <= DUR_WB;
        default:   tmr <= '0;
      endcase
    end else if (tmr != '0) begin
      tmr <= tmr - 1'b1;
    end
  end
  assign tmrDone = (tmr == '0);

  // address shift register and cycle count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrSr   <= '0;
      addrLeft <= '0;
    end else if (stb.reqAccept) begin
      addrSr   <= addrInit;
      addrLeft <= ACNT_W'(ADDR_CYC);
    end else if (stb.shiftAddr) begin
      addrSr   <= addrSr >> 8;
      addrLeft <= addrLeft - 1'b1;
    end
  end
  assign addrLast  = (addrLeft == ACNT_W'(1));
  assign nandIoOut = stb.ioUseAddr ? addrSr[7:0] : stb.cmdByte;

  // ready/busy timeout counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (stb.busyClr) begin
      busyCnt <= '0;
    end else if (stb.busyEn && !busyTimeout) begin
      busyCnt <= busyCnt + 1'b1;
    end
  end
  assign busyTimeout = (busyCnt >= BUSY_W'(TIMEOUT_CYC));

  // byte count and output holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteLeft  <= '0;
      dataValid <= 1'b0;
      dataByte  <= '0;
      dataLast  <= 1'b0;
    end else begin
      if (stb.reqAccept) begin
        byteLeft <= reqLen;
      end else if (stb.capData) begin
        byteLeft <= byteLeft - 1'b1;
      end
      if (stb.capData) begin
        dataValid <= 1'b1;
        dataByte  <= nandIoIn;
        dataLast  <= (byteLeft == LEN_W'(1));
      end else if (dataValid && dataReady) begin
        dataValid <= 1'b0;
        dataLast  <= 1'b0;
      end
    end
  end
  assign bytesDone = (byteLeft == '0);

  // result flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resUncorr  <= 1'b0;
      resCorr    <= 1'b0;
      resTimeout <= 1'b0;
    end else if (stb.reqAccept) begin
      resUncorr  <= 1'b0;
      resCorr    <= 1'b0;
      resTimeout <= 1'b0;
    end else begin
      if (stb.capStatus) begin
        resUncorr <= nandIoIn[BIT_UNCORR];
        resCorr   <= nandIoIn[BIT_CORR];
      end
      if (stb.setTimeout) begin
        resTimeout <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/nandRdCtrl.sv
module nandRdCtrl
  import nandRdPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      nandRbN,
  input  logic      tmrDone,
  input  logic      addrLast,
  input  logic      bytesDone,
  input  logic      busyTimeout,
  input  logic      dataValid,
  output dpStrobe_t stb,
  output logic      reqReady,
  output logic      doneStb,
  output logic      nandCle,
  output logic      nandAle,
  output logic      nandWeN,
  output logic      nandReN,
  output logic      nandIoOe
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_CMD_RD,
    S_ADDR,
    S_CMD_CONF,
    S_WAIT_WB,
    S_WAIT_RDY,
    S_CMD_STAT,
    S_RD_STAT,
    S_CMD_OUT,
    S_DATA,
    S_DRAIN,
    S_DONE
  } state_e;

  // write cycle: A setup, B strobe low, C hold
  // read cycle:  A strobe low, B strobe high, C wait for stream slot
  typedef enum logic [1:0] {PH_A, PH_B, PH_C} phase_e;

  state_e state, stateNx;
  phase_e ph, phNx;
  logic   isWrite, isRead, writeEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      ph    <= PH_A;
    end else begin
      state <= stateNx;
      ph    <= phNx;
    end
  end

  assign isWrite = (state == S_CMD_RD) || (state == S_ADDR) || (state == S_CMD_CONF) ||
                   (state == S_CMD_STAT) || (state == S_CMD_OUT);
  assign isRead  = (state == S_RD_STAT) || (state == S_DATA);

  assign nandCle  = isWrite && (state != S_ADDR);
  assign nandAle  = (state == S_ADDR);
  assign nandIoOe = isWrite;
  assign nandWeN  = !(isWrite && (ph == PH_B));
  assign nandReN  = !(isRead && (ph == PH_A));
  assign reqReady = (state == S_IDLE);
  assign doneStb  = (state == S_DONE);

  always_comb begin
    stb       = '0;
    stb.tmrSel = TMR_SETUP;
    stateNx   = state;
    phNx      = ph;
    writeEnd  = 1'b0;

    stb.ioUseAddr = (state == S_ADDR);
    case (state)
      S_CMD_CONF: stb.cmdByte = CMD_CONFIRM;
      S_CMD_STAT: stb.cmdByte = CMD_STATUS;
      default:    stb.cmdByte = CMD_READ;
    endcase

    // shared write-cycle phase walk
    if (isWrite && tmrDone) begin
      case (ph)
        PH_A: begin
          stb.tmrStart = 1'b1;
          stb.tmrSel   = TMR_WE;
          phNx         = PH_B;
        end
        PH_B: begin
          stb.tmrStart = 1'b1;
          stb.tmrSel   = TMR_HOLD;
          phNx         = PH_C;
        end
        default: writeEnd = 1'b1;
      endcase
    end

    case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.reqAccept = 1'b1;
          stb.tmrStart  = 1'b1;
          stb.tmrSel    = TMR_SETUP;
          stateNx       = S_CMD_RD;
          phNx          = PH_A;
        end
      end
      S_CMD_RD: begin
        if (writeEnd) begin
          stb.tmrStart = 1'b1;
          stb.tmrSel   = TMR_SETUP;
          stateNx      = S_ADDR;
          phNx         = PH_A;
        end
      end
      S_ADDR: begin
        if (writeEnd) begin
          stb.shiftAddr = 1'b1;
          stb.tmrStart  = 1'b1;
          stb.tmrSel    = TMR_SETUP;
          phNx          = PH_A;
          if (addrLast) stateNx = S_CMD_CONF;
        end
      end
      S_CMD_CONF: begin
        if (writeEnd) begin
          stb.busyClr  = 1'b1;
          stb.tmrStart = 1'b1;
          stb.tmrSel   = TMR_WB;
          stateNx      = S_WAIT_WB;
        end
      end
      S_WAIT_WB: begin
        stb.busyEn = 1'b1;
        if (tmrDone) stateNx = S_WAIT_RDY;
      end
      S_WAIT_RDY: begin
        stb.busyEn = 1'b1;
        if (nandRbN) begin
          stb.tmrStart = 1'b1;
          stb.tmrSel   = TMR_SETUP;
          stateNx      = S_CMD_STAT;
          phNx         = PH_A;
        end else if (busyTimeout) begin
          stb.setTimeout = 1'b1;
          stateNx        = S_DONE;
        end
      end
      S_CMD_STAT: begin
        if (writeEnd) begin
          stb.tmrStart = 1'b1;
          stb.tmrSel   = TMR_RE;
          stateNx      = S_RD_STAT;
          phNx         = PH_A;
        end
      end
      S_RD_STAT: begin
        if (tmrDone && ph == PH_A) begin
          stb.capStatus = 1'b1;
          stb.tmrStart  = 1'b1;
          stb.tmrSel    = TMR_REH;
          phNx          = PH_B;
        end else if (tmrDone) begin
          stb.tmrStart = 1'b1;
          stb.tmrSel   = TMR_SETUP;
          stateNx      = S_CMD_OUT;
          phNx         = PH_A;
        end
      end
      S_CMD_OUT: begin
        if (writeEnd) begin
          stateNx = S_DATA;
          phNx    = PH_C;
        end
      end
      S_DATA: begin
        case (ph)
          PH_C: begin
            if (!dataValid) begin
              stb.tmrStart = 1'b1;
              stb.tmrSel   = TMR_RE;
              phNx         = PH_A;
            end
          end
          PH_A: begin
            if (tmrDone) begin
              stb.capData  = 1'b1;
              stb.tmrStart = 1'b1;
              stb.tmrSel   = TMR_REH;
              phNx         = PH_B;
            end
          end
          default: begin
            if (tmrDone) begin
              phNx = PH_C;
              if (bytesDone) stateNx = S_DRAIN;
            end
          end
        endcase
      end
      S_DRAIN: begin
        if (!dataValid) stateNx = S_DONE;
      end
      S_DONE: begin
        stateNx = S_IDLE;
        phNx    = PH_A;
      end
      default: stateNx = S_IDLE;
    endcase
  end

endmodule

// File: rtl/nandPageReader.sv
module nandPageReader
  import nandRdPkg::*;
#(
  parameter int PAGE_BYTES  = 2112,
  parameter int ROW_W       = 24,
  parameter int TMR_W       = 8,
  parameter int T_SETUP     = 2,
  parameter int T_WE        = 2,
  parameter int T_HOLD      = 1,
  parameter int T_RE        = 2,
  parameter int T_REH       = 1,
  parameter int T_WB        = 4,
  parameter int TIMEOUT_CYC = 2000,
  parameter int BIT_UNCORR  = 0,
  parameter int BIT_CORR    = 3,
  localparam int COL_W      = $clog2(PAGE_BYTES),
  localparam int LEN_W      = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [COL_W-1:0] reqCol,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [LEN_W-1:0] reqLen,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  input  logic             nandRbN,
  output logic [7:0]       nandIoOut,
  output logic             nandIoOe,
  input  logic [7:0]       nandIoIn,
  output logic             dataValid,
  input  logic             dataReady,
  output logic [7:0]       dataByte,
  output logic             dataLast,
  output logic             doneStb,
  output logic             resUncorr,
  output logic             resCorr,
  output logic             resTimeout
);

  dpStrobe_t stb;
  logic      tmrDone, addrLast, bytesDone, busyTimeout;

  nandRdCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .nandRbN    (nandRbN),
    .tmrDone    (tmrDone),
    .addrLast   (addrLast),
    .bytesDone  (bytesDone),
    .busyTimeout(busyTimeout),
    .dataValid  (dataValid),
    .stb        (stb),
    .reqReady   (reqReady),
    .doneStb    (doneStb),
    .nandCle    (nandCle),
    .nandAle    (nandAle),
    .nandWeN    (nandWeN),
    .nandReN    (nandReN),
    .nandIoOe   (nandIoOe)
  );

  nandRdDatapath #(
    .COL_W      (COL_W),
    .ROW_W      (ROW_W),
    .LEN_W      (LEN_W),
    .TMR_W      (TMR_W),
    .T_SETUP    (T_SETUP),
    .T_WE       (T_WE),
    .T_HOLD     (T_HOLD),
    .T_RE       (T_RE),
    .T_REH      (T_REH),
    .T_WB       (T_WB),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .BIT_UNCORR (BIT_UNCORR),
    .BIT_CORR   (BIT_CORR)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .reqCol     (reqCol),
    .reqRow     (reqRow),
    .reqLen     (reqLen),
    .nandIoIn   (nandIoIn),
    .dataReady  (dataReady),
    .tmrDone    (tmrDone),
    .addrLast   (addrLast),
    .bytesDone  (bytesDone),
    .busyTimeout(busyTimeout),
    .nandIoOut  (nandIoOut),
    .dataValid  (dataValid),
    .dataByte   (dataByte),
    .dataLast   (dataLast),
    .resUncorr  (resUncorr),
    .resCorr    (resCorr),
    .resTimeout (resTimeout)
  );

endmodule

// File: rtl/nandPageReaderChk.sv
module nandPageReaderChk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       reqReady,
  input logic       nandCle,
  input logic       nandAle,
  input logic       nandWeN,
  input logic       nandReN,
  input logic       nandRbN,
  input logic       nandIoOe,
  input logic       dataValid,
  input logic       dataReady,
  input logic [7:0] dataByte,
  input logic       dataLast,
  input logic       doneStb,
  input logic       resUncorr,
  input logic       resCorr,
  input logic       resTimeout
);

  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_quiet_while_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    !nandRbN |-> (nandWeN && nandReN));

  p_io_owner_r7: assert property (@(posedge clk) disable iff (!rstN)
    nandIoOe |-> (nandCle != nandAle));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandIoOe);

  p_we_setup_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |-> ($past(nandIoOe) && $stable(nandCle) && $stable(nandAle)));

  p_we_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> nandIoOe);

  p_stream_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataReady) |=> (dataValid && $stable(dataByte) && $stable(dataLast)));

  p_re_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandReN) |-> !dataValid);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  p_result_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && $past(reqReady)) |-> ($stable(resUncorr) && $stable(resCorr) && $stable(resTimeout)));

  p_timeout_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    resTimeout |-> (!resUncorr && !resCorr));

endmodule

bind nandPageReader nandPageReaderChk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .nandCle   (nandCle),
  .nandAle   (nandAle),
  .nandWeN   (nandWeN),
  .nandReN   (nandReN),
  .nandRbN   (nandRbN),
  .nandIoOe  (nandIoOe),
  .dataValid (dataValid),
  .dataReady (dataReady),
  .dataByte  (dataByte),
  .dataLast  (dataLast),
  .doneStb   (doneStb),
  .resUncorr (resUncorr),
  .resCorr   (resCorr),
  .resTimeout(resTimeout)
);

// File: tb/test_nandPageReader.sv
`timescale 1ns/1ps
module test_nandPageReader;

  localparam int T_SETUP = 2;
  localparam int T_WE    = 2;
  localparam int T_HOLD  = 1;
  localparam int T_RE    = 2;
  localparam int T_REH   = 1;
  localparam int T_WB    = 4;
  localparam int TMO     = 2000;

  typedef struct packed {
    logic [11:0] col;
    logic [23:0] row;
    logic [11:0] len;
    logic [7:0]  stat;
    logic [15:0] busy;
    logic [7:0]  stall;
  } vec_t;

  // col, row, len, status byte, busy cycles, ready stall mask
  localparam vec_t VEC [5] = '{
    '{12'h000, 24'h012345, 12'd16,  8'h00, 16'd20,  8'h00},
    '{12'h7F3, 24'hABCDEF, 12'd40,  8'h01, 16'd100, 8'hA5},
    '{12'h800, 24'h000001, 12'd64,  8'h08, 16'd5,   8'h3C},
    '{12'h83F, 24'hFFFFFF, 12'd1,   8'h09, 16'd300, 8'h7F},
    '{12'h123, 24'h800000, 12'd200, 8'hF6, 16'd1,   8'h11}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [11:0] reqCol = '0;
  logic [23:0] reqRow = '0;
  logic [11:0] reqLen = '0;
  logic reqReady, nandCle, nandAle, nandWeN, nandReN, nandIoOe;
  logic [7:0] nandIoOut, nandIoIn, dataByte;
  logic dataValid, dataLast, doneStb, resUncorr, resCorr, resTimeout;
  logic dataReady = 1'b1;
  logic devRbN = 1'b1;

  always #2.5 clk = ~clk;

  nandPageReader #(
    .T_SETUP(T_SETUP), .T_WE(T_WE), .T_HOLD(T_HOLD), .T_RE(T_RE),
    .T_REH(T_REH), .T_WB(T_WB), .TIMEOUT_CYC(TMO)
  ) i_nandPageReader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCol(reqCol), .reqRow(reqRow), .reqLen(reqLen),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
    .nandRbN(devRbN), .nandIoOut(nandIoOut), .nandIoOe(nandIoOe), .nandIoIn(nandIoIn),
    .dataValid(dataValid), .dataReady(dataReady), .dataByte(dataByte), .dataLast(dataLast),
    .doneStb(doneStb), .resUncorr(resUncorr), .resCorr(resCorr), .resTimeout(resTimeout)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] devByte(input int idx);
    logic [7:0] b;
    b = 8'(idx * 13) ^ 8'(idx >> 3);
    return b + 8'h5A;
  endfunction

  // device model state
  bit        devStatMode = 1'b0;
  int        devColPtr = 0;
  logic [7:0] devAddr [5];
  int        devAddrCnt = 0;
  int        devBusyLeft = 0;
  int        devBusyCyc = 1;
  bit        devHang = 1'b0;
  logic [7:0] devStatus = '0;

  assign nandIoIn = devStatMode ? devStatus : devByte(devColPtr);

  // observation state
  logic [9:0] wrLog [16];
  int  wrCnt = 0, weLow = 0, reLow = 0, weBad = 0, reBad = 0, rePulses = 0;
  int  ioBad = 0, busyBad = 0, stallBad = 0;
  int  rxCnt = 0, rxBad = 0, lastCnt = 0, lastBad = 0, doneCnt = 0;
  int  cyc = 0, confCyc = 0, gap = -1;
  bit  awaitGap = 1'b0;
  bit  prevWe = 1'b1, prevRe = 1'b1;
  logic [7:0] stallMask = '0;
  int  opCol = 0, opLen = 0;
  bit  gotUnc = 1'b0, gotCor = 1'b0, gotTmo = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (devBusyLeft > 0) begin
        devBusyLeft--;
        if (devBusyLeft == 0) devRbN = 1'b1;
      end
      if (!devRbN && (!nandWeN || !nandReN)) busyBad++;
      if (nandIoOe && !nandReN) ioBad++;
      if (!nandWeN) weLow++;
      if (!nandWeN && prevWe && awaitGap) begin
        gap = cyc - confCyc;
        awaitGap = 1'b0;
      end
      if (nandWeN && !prevWe) begin
        if (weLow != T_WE) weBad++;
        weLow = 0;
        if (wrCnt < 16) wrLog[wrCnt] = {nandCle, nandAle, nandIoOut};
        wrCnt++;
        if (nandAle) begin
          if (devAddrCnt < 5) devAddr[devAddrCnt] = nandIoOut;
          devAddrCnt++;
        end else if (nandCle && nandIoOut == 8'h00) begin
          devStatMode = 1'b0;
          devAddrCnt = 0;
        end else if (nandCle && nandIoOut == 8'h30) begin
          devColPtr = {devAddr[1][3:0], devAddr[0]};
          devRbN = 1'b0;
          devBusyLeft = devHang ? 0 : devBusyCyc;
          confCyc = cyc;
          awaitGap = 1'b1;
        end else if (nandCle && nandIoOut == 8'h70) begin
          devStatMode = 1'b1;
        end
      end
      if (!nandReN) reLow++;
      if (!nandReN && prevRe && dataValid) stallBad++;
      if (nandReN && !prevRe) begin
        if (reLow != T_RE) reBad++;
        reLow = 0;
        rePulses++;
        if (!devStatMode) devColPtr++;
      end
      prevWe = nandWeN;
      prevRe = nandReN;
      // stream consumer
      dataReady = !stallMask[cyc % 8];
      if (dataValid && dataReady) begin
        if (dataByte != devByte(opCol + rxCnt)) rxBad++;
        if (dataLast) lastCnt++;
        if (dataLast != (rxCnt == opLen - 1)) lastBad++;
        rxCnt++;
      end
      if (doneStb) begin
        doneCnt++;
        gotUnc = resUncorr;
        gotCor = resCorr;
        gotTmo = resTimeout;
      end
    end
  end

  task automatic runOp(input vec_t v, input bit hang, input string tag);
    logic [9:0] exp [9];
    int nWr, seqBad, minGap, wait_n;
    exp[0] = {2'b10, 8'h00};
    exp[1] = {2'b01, v.col[7:0]};
    exp[2] = {2'b01, 4'h0, v.col[11:8]};
    exp[3] = {2'b01, v.row[7:0]};
    exp[4] = {2'b01, v.row[15:8]};
    exp[5] = {2'b01, v.row[23:16]};
    exp[6] = {2'b10, 8'h30};
    exp[7] = {2'b10, 8'h70};
    exp[8] = {2'b10, 8'h00};
    nWr = hang ? 7 : 9;
    @(negedge clk);
    wrCnt = 0; weBad = 0; reBad = 0; rePulses = 0; ioBad = 0; busyBad = 0;
    stallBad = 0; rxCnt = 0; rxBad = 0; lastCnt = 0; lastBad = 0; doneCnt = 0;
    gap = -1; awaitGap = 1'b0;
    devStatus = v.stat; devBusyCyc = int'(v.busy); devHang = hang;
    stallMask = v.stall; opCol = int'(v.col); opLen = int'(v.len);
    reqCol = v.col; reqRow = v.row; reqLen = v.len; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R11", {tag, " ready dropped after accept"}, int'(reqReady), 0);
    wait_n = 0;
    while (doneCnt == 0 && wait_n < 30000) begin
      @(negedge clk);
      wait_n++;
    end
    repeat (5) @(negedge clk);
    check("R4", {tag, " single done pulse"}, doneCnt, 1);
    check("R1", {tag, " write cycle count"}, wrCnt, nWr);
    seqBad = 0;
    for (int k = 0; k < nWr; k++) if (k < wrCnt && wrLog[k] != exp[k]) seqBad++;
    check("R1", {tag, " command/address bytes"}, seqBad, 0);
    check("R8", {tag, " WE# low width errors"}, weBad, 0);
    check("R7", {tag, " IO driven during read"}, ioBad, 0);
    check("R2", {tag, " strobes while busy"}, busyBad, 0);
    if (hang) begin
      check("R9", {tag, " timeout flag"}, int'(gotTmo), 1);
      check("R9", {tag, " flags on timeout"}, int'({gotUnc, gotCor}), 0);
      check("R9", {tag, " no RE# pulses"}, rePulses, 0);
      check("R9", {tag, " no bytes"}, rxCnt, 0);
      devHang = 1'b0;
      devRbN = 1'b1;
    end else begin
      minGap = ((T_HOLD + T_WB) > int'(v.busy) ? (T_HOLD + T_WB) : int'(v.busy)) + T_SETUP;
      check("R2", {tag, " wait after confirm"}, int'(gap >= minGap), 1);
      check("R3", {tag, " RE# pulse count"}, rePulses, opLen + 1);
      check("R8", {tag, " RE# low width errors"}, reBad, 0);
      check("R4", {tag, " uncorrectable flag"}, int'(gotUnc), int'(v.stat[0]));
      check("R4", {tag, " corrected flag"}, int'(gotCor), int'(v.stat[3]));
      check("R4", {tag, " timeout flag clear"}, int'(gotTmo), 0);
      check("R5", {tag, " byte count"}, rxCnt, opLen);
      check("R5", {tag, " byte values"}, rxBad, 0);
      check("R5", {tag, " last marker"}, lastCnt * 1000 + lastBad, 1000);
      check("R6", {tag, " RE# started with byte waiting"}, stallBad, 0);
      check("R4", {tag, " uncorrectable held"}, int'(resUncorr), int'(v.stat[0]));
      check("R4", {tag, " corrected held"}, int'(resCorr), int'(v.stat[3]));
    end
    check("R11", {tag, " ready after done"}, int'(reqReady), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: state while held in reset
    check("R10", "outputs in reset",
          int'({reqReady, nandWeN, nandReN, nandCle, nandAle, nandIoOe,
                dataValid, doneStb, resUncorr, resCorr, resTimeout}), int'(11'b11100000000));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10", "outputs after reset",
          int'({reqReady, nandWeN, nandReN, nandCle, nandAle, nandIoOe,
                dataValid, doneStb, resUncorr, resCorr, resTimeout}), int'(11'b11100000000));

    for (int i = 0; i < 5; i++) begin
      runOp(VEC[i], 1'b0, $sformatf("vec%0d", i));
    end

    // full page including spare area, with stalls
    runOp('{12'h000, 24'h000777, 12'd2112, 8'h08, 16'd50, 8'h24}, 1'b0, "fullpage");
    // R/B# never returns: timeout
    runOp('{12'h010, 24'h00ABCD, 12'd8, 8'h01, 16'd1, 8'h00}, 1'b1, "timeout");
    // recovery after timeout clears the timeout flag
    runOp('{12'h83F, 24'h000002, 12'd1, 8'h00, 16'd3, 8'h00}, 1'b0, "recover");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual run still active expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule